// File: doc/BRIEF.md
# Mode-Selected Ripple ALU Slice

This block is a purely combinational arithmetic/logic unit of parameterizable width, four bits by default. It is made of a chain of identical one-bit stages. Each stage holds a full adder, an element that conditions the B operand bit before it reaches the adder, and a four-way bitwise function multiplexer. A final two-way choice in every stage picks either the adder sum or the bitwise result.

A single mode line picks the arithmetic or the logic path. In arithmetic mode a two-bit function select chooses how B is presented to the adder: forced to zero, passed through, inverted, or forced to all ones. The carry input acts as a fourth select bit and adds one at the least significant stage. Together these give eight arithmetic functions from one adder chain. In logic mode the same two select bits pick one of four bitwise functions, and the carry path is silenced.

Stage carries ripple upward, so each stage's carry output feeds the next stage's carry input. The carry output of the block is taken from the top stage. The block has no state, no clock and no reset. It is meant to sit between operand registers and a destination register inside a datapath.

Top module: `mode_ripple_alu`

## Requirements
- R1: `mode_logic`=0 presents the arithmetic result on `result`, and `mode_logic`=1 presents the bitwise result. The choice is made in the same evaluation as the operands.
- R2: With `mode_logic`=0 and `fsel`=01 (B passed through), {`carry_out`,`result`} equals A + B + `carry_in` as unsigned numbers.
- R3: With `mode_logic`=0 and `fsel`=00 (B forced to zero), `result` equals A when `carry_in`=0 and A+1 modulo 2^W when `carry_in`=1.
- R4: With `mode_logic`=0 and `fsel`=10 (B inverted), the result is A + ~B + `carry_in`. With `carry_in`=1 this is A−B modulo 2^W, and `carry_out`=1 exactly when A ≥ B as unsigned numbers.
- R5: With `mode_logic`=0 and `fsel`=11 (B forced to all ones), `result` equals A−1 modulo 2^W when `carry_in`=0 and equals A when `carry_in`=1.
- R6: In arithmetic mode `carry_out` is bit W of the full (W+1)-bit sum of A, the conditioned B and `carry_in`. `carry_in` enters at bit 0, and the carry ripples through every stage.
- R7: With `mode_logic`=1, `fsel` selects the bitwise function: 00 gives A OR B, 01 gives A XOR B, 10 gives A AND B, and 11 gives NOT A.
- R8: With `mode_logic`=1, `carry_out` is 0 and `carry_in` has no effect on `result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand, conditioned in arithmetic mode |
| mode_logic | input | 1 | 0 = arithmetic path, 1 = bitwise path |
| fsel | input | 2 | Function select within the chosen mode |
| carry_in | input | 1 | Carry into bit 0; acts as a fourth select bit in arithmetic mode |
| result | output | WIDTH | Selected result |
| carry_out | output | 1 | Carry out of the top stage; 0 in logic mode |

## Verification
The block holds no state, so a wrong value inside a stage shows at the ports in the same evaluation as the operands that expose it. A faulty conditioning element or a faulty logic multiplexer corrupts its own `result` bit. A faulty carry corrupts every higher bit and `carry_out`, and it only appears for operand pairs that make a carry propagate through that stage. The full sweep of operands and selects reaches every stage, every select value and every carry path. Directed vectors pin the wrap, borrow and equality corners.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

    // Conditioning applied to the B bit in arithmetic mode
    typedef enum logic [1:0] {
        BSEL_ZERO = 2'b00,
        BSEL_TRUE = 2'b01,
        BSEL_INV  = 2'b10,
        BSEL_ONES = 2'b11
    } bsel_e;

    // Bitwise function chosen in logic mode
    typedef enum logic [1:0] {
        LFN_OR   = 2'b00,
        LFN_XOR  = 2'b01,
        LFN_AND  = 2'b10,
        LFN_NOTA = 2'b11
    } lfn_e;

endpackage

// File: rtl/alu_b_cond.sv
module alu_b_cond
    import alu_slice_pkg::*;
(
    input  logic       b_bit,
    input  logic [1:0] fsel,
    output logic       b_out
);

    bsel_e sel;

    always_comb begin
        sel = bsel_e'(fsel);
        unique case (sel)
            BSEL_ZERO: b_out = 1'b0;
            BSEL_TRUE: b_out = b_bit;
            BSEL_INV:  b_out = ~b_bit;
            BSEL_ONES: b_out = 1'b1;
        endcase
    end

endmodule

// File: rtl/alu_logic_mux.sv
module alu_logic_mux
    import alu_slice_pkg::*;
(
    input  logic       a_bit,
    input  logic       b_bit,
    input  logic [1:0] fsel,
    output logic       l_out
);

    lfn_e fn;

    always_comb begin
        fn = lfn_e'(fsel);
        unique case (fn)
            LFN_OR:   l_out = a_bit | b_bit;
            LFN_XOR:  l_out = a_bit ^ b_bit;
            LFN_AND:  l_out = a_bit & b_bit;
            LFN_NOTA: l_out = ~a_bit;
        endcase
    end

endmodule

// File: rtl/alu_bit_stage.sv
module alu_bit_stage (
    input  logic       a_bit,
    input  logic       b_bit,
    input  logic       c_in,
    input  logic       mode_logic,
    input  logic [1:0] fsel,
    output logic       f_bit,
    output logic       c_out,
    output logic       b_used
);

    logic sum_bit;
    logic gen_carry;
    logic lgc_bit;

    alu_b_cond u_cond (
        .b_bit (b_bit),
        .fsel  (fsel),
        .b_out (b_used)
    );

    alu_logic_mux u_lmux (
        .a_bit (a_bit),
        .b_bit (b_bit),
        .fsel  (fsel),
        .l_out (lgc_bit)
    );

    // Full adder on A and conditioned B
    always_comb begin
        sum_bit   = a_bit ^ b_used ^ c_in;
        gen_carry = (a_bit & b_used) | (c_in & (a_bit ^ b_used));
    end

    // Two-way result choice; carry silenced on the bitwise path
    always_comb begin
        f_bit = mode_logic ? lgc_bit : sum_bit;
        c_out = mode_logic ? 1'b0 : gen_carry;
    end

    always_comb begin
        if (mode_logic) begin
            AST_STAGE_NO_CARRY: assert (c_out == 1'b0); // R8
        end
    end

endmodule

// File: rtl/mode_ripple_alu.sv
module mode_ripple_alu #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             mode_logic,
    input  logic [1:0]       fsel,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);

    localparam int CHAIN_LEN = WIDTH + 1;

    logic [CHAIN_LEN-1:0] carry_chain;
    logic [WIDTH-1:0]     b_cond_vec;

    assign carry_chain[0] = carry_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        alu_bit_stage u_stage (
            .a_bit      (opnd_a[i]),
            .b_bit      (opnd_b[i]),
            .c_in       (carry_chain[i]),
            .mode_logic (mode_logic),
            .fsel       (fsel),
            .f_bit      (result[i]),
            .c_out      (carry_chain[i+1]),
            .b_used     (b_cond_vec[i])
        );
    end

    assign carry_out = carry_chain[WIDTH];

    // Guards: the rippled chain against a wide add of the same terms
    logic [WIDTH:0] wide_sum;

    always_comb begin
        wide_sum = {1'b0, opnd_a} + {1'b0, b_cond_vec} + {{WIDTH{1'b0}}, carry_in};
        if (!mode_logic) begin
            AST_RIPPLE_MATCH: assert ({carry_out, result} == wide_sum); // R6
            if (fsel == 2'b10 && carry_in) begin
                AST_NO_BORROW: assert (carry_out == (opnd_a >= opnd_b)); // R4
            end
            if (fsel == 2'b00 && !carry_in) begin
                AST_TRANSFER: assert (result == opnd_a); // R3
            end
            if (fsel == 2'b11 && !carry_in) begin
                AST_DECREMENT: assert (result == WIDTH'(opnd_a - 1'b1)); // R5
            end
        end else begin
            AST_LOGIC_CARRY_ZERO: assert (carry_out == 1'b0); // R8
            if (fsel == 2'b11) begin
                AST_LOGIC_NOT: assert (result == ~opnd_a); // R7
            end
        end
    end

endmodule

// File: tb/mode_ripple_alu_tb_top.sv
module mode_ripple_alu_tb_top;

    localparam int W  = 4;
    localparam int NV = 19;
    localparam int WATCHDOG_CYCLES = 20000;

    // {mode, fsel, cin, a, b, expected result, expected carry}
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 2'b01, 1'b0, 4'h3, 4'h4, 4'h7, 1'b0},  // R2
        {1'b0, 2'b01, 1'b0, 4'hF, 4'h1, 4'h0, 1'b1},  // R6
        {1'b0, 2'b01, 1'b1, 4'h7, 4'h8, 4'h0, 1'b1},  // R6
        {1'b0, 2'b00, 1'b0, 4'h9, 4'h5, 4'h9, 1'b0},  // R3
        {1'b0, 2'b00, 1'b1, 4'hF, 4'h0, 4'h0, 1'b1},  // R3
        {1'b0, 2'b10, 1'b1, 4'h9, 4'h4, 4'h5, 1'b1},  // R4
        {1'b0, 2'b10, 1'b1, 4'h4, 4'h9, 4'hB, 1'b0},  // R4
        {1'b0, 2'b10, 1'b1, 4'h6, 4'h6, 4'h0, 1'b1},  // R4
        {1'b0, 2'b10, 1'b0, 4'h6, 4'h6, 4'hF, 1'b0},  // R4
        {1'b0, 2'b11, 1'b0, 4'h0, 4'h3, 4'hF, 1'b0},  // R5
        {1'b0, 2'b11, 1'b0, 4'h5, 4'h0, 4'h4, 1'b1},  // R5
        {1'b0, 2'b11, 1'b1, 4'h5, 4'h0, 4'h5, 1'b1},  // R5
        {1'b1, 2'b00, 1'b0, 4'hA, 4'h5, 4'hF, 1'b0},  // R7
        {1'b1, 2'b01, 1'b1, 4'hC, 4'hA, 4'h6, 1'b0},  // R8
        {1'b1, 2'b10, 1'b1, 4'hC, 4'hA, 4'h8, 1'b0},  // R8
        {1'b1, 2'b11, 1'b0, 4'h3, 4'hF, 4'hC, 1'b0},  // R7
        {1'b0, 2'b10, 1'b0, 4'hC, 4'hA, 4'h1, 1'b1},  // R1
        {1'b1, 2'b10, 1'b0, 4'hC, 4'hA, 4'h8, 1'b0},  // R1
        {1'b1, 2'b11, 1'b1, 4'h0, 4'h0, 4'hF, 1'b0}   // R8
    };

    logic         clk = 1'b0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic         mode_logic = 1'b0;
    logic [1:0]   fsel = 2'b00;
    logic         carry_in = 1'b0;
    logic [W-1:0] result;
    logic         carry_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mode_ripple_alu #(.WIDTH(W)) dut_i (
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .mode_logic (mode_logic),
        .fsel       (fsel),
        .carry_in   (carry_in),
        .result     (result),
        .carry_out  (carry_out)
    );

    task automatic check(input string req, input logic [W-1:0] exp_f, input logic exp_c);
        checks++;
        if (result !== exp_f || carry_out !== exp_c) begin
            errors++;
            $display("FAIL %s mode=%0b fsel=%0b cin=%0b a=%h b=%h : got f=%h c=%0b expected f=%h c=%0b",
                     req, mode_logic, fsel, carry_in, opnd_a, opnd_b,
                     result, carry_out, exp_f, exp_c);
        end
    endtask

    // Independent model written from the requirements
    task automatic model(input logic m, input logic [1:0] fs, input logic ci,
                         input logic [W-1:0] a, input logic [W-1:0] b,
                         output logic [W-1:0] f, output logic c, output string req);
        int mask;
        int bb;
        int s;
        mask = (1 << W) - 1;
        if (!m) begin
            case (fs)
                2'b00:   begin bb = 0;             req = "R3"; end
                2'b01:   begin bb = int'(b);       req = "R2"; end
                2'b10:   begin bb = ~int'(b) & mask; req = "R4"; end
                default: begin bb = mask;          req = "R5"; end
            endcase
            s = int'(a) + bb + int'(ci);
            f = W'(s & mask);
            c = s[W];
        end else begin
            case (fs)
                2'b00:   f = a | b;
                2'b01:   f = a ^ b;
                2'b10:   f = a & b;
                default: f = ~a;
            endcase
            c = 1'b0;
            req = "R7";
        end
    endtask

    task automatic apply(input logic m, input logic [1:0] fs, input logic ci,
                         input logic [W-1:0] a, input logic [W-1:0] b);
        @(posedge clk);
        mode_logic = m;
        fsel       = fs;
        carry_in   = ci;
        opnd_a     = a;
        opnd_b     = b;
        @(negedge clk);
    endtask

    initial begin : watchdog
        int n;
        n = 0;
        while (!done && n < WATCHDOG_CYCLES) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [W-1:0] ef;
        logic         ec;
        string        rq;

        // Start state: all inputs zero gives A+0+0 = 0, carry 0 (R3)
        @(negedge clk);
        check("R3", '0, 1'b0);

        // Directed table
        for (int k = 0; k < NV; k++) begin
            apply(VEC[k][16], VEC[k][15:14], VEC[k][13], VEC[k][12:9], VEC[k][8:5]);
            check("R1/table", VEC[k][4:1], VEC[k][0]);
        end

        // Exhaustive sweep of operands, mode, select and carry
        for (int sel = 0; sel < 16; sel++) begin
            for (int a = 0; a < (1 << W); a++) begin
                for (int b = 0; b < (1 << W); b++) begin
                    apply(sel[3], sel[2:1], sel[0], W'(a), W'(b));
                    model(sel[3], sel[2:1], sel[0], W'(a), W'(b), ef, ec, rq);
                    check(rq, ef, ec);
                    if (sel[3]) begin
                        // R8: carry path silent in logic mode
                        checks++;
                        if (carry_out !== 1'b0) begin
                            errors++;
                            $display("FAIL R8 carry_out got %0b expected 0", carry_out);
                        end
                    end
                    if (!sel[3] && sel[2:1] == 2'b10 && sel[0]) begin
                        // R4: no-borrow flag against integer compare
                        checks++;
                        if (carry_out !== (a >= b)) begin
                            errors++;
                            $display("FAIL R4 borrow a=%0d b=%0d got %0b expected %0b",
                                     a, b, carry_out, (a >= b));
                        end
                    end
                end
            end
        end

        // R8: toggling carry_in in logic mode leaves result unchanged
        apply(1'b1, 2'b01, 1'b0, 4'h5, 4'h3);
        ef = result;
        apply(1'b1, 2'b01, 1'b1, 4'h5, 4'h3);
        check("R8", ef, 1'b0);

        // R6: full carry ripple from bit 0 to the top
        apply(1'b0, 2'b01, 1'b1, 4'hF, 4'h0);
        check("R6", 4'h0, 1'b1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule